// File: doc/BRIEF.md
# Receive Descriptor Status Word Writer

This block sits between the receive FIFO and the descriptor write-back path of a DMA engine. It watches the received byte stream, which carries start-of-frame and end-of-frame marks, and lays each frame across a chain of descriptors. Each descriptor offers two buffers. For every descriptor that the frame touches, the block produces one 32-bit status word and a one-cycle write strobe. The word carries the running byte total, the first/last placement flags, the truncation flag, the MAC error flags and an error summary.

The environment presents the buffer sizes of the current descriptor and the ownership bit of the descriptor after it. It steps to the next descriptor in the same cycle that a write strobe appears. When a descriptor fills before the frame ends and the next one is not owned, the frame is cut short: the current descriptor is closed as the last one and flagged as truncated, and the rest of the frame is swallowed. A descriptor whose two buffers are both empty holds no data. It is closed at once, and the incoming byte is held back for that cycle.

Top module: `rx_desc_status_writer`

## Requirements
- R1: After reset, statusWe is 0, statusWord is 0 and byteReady is 1.
- R2: Bits 29:16 of each word hold the number of bytes of the current frame placed up to and including that descriptor. The count restarts at every start of frame and saturates at 16383.
- R3: Exactly one word is written per descriptor, with statusWe high for one cycle in the cycle after the descriptor closes. A descriptor closes when its capacity (buffer 1 size plus buffer 2 size) is filled, when the end-of-frame byte is accepted, or when the capacity is zero while a frame is open.
- R4: Bit 9 is set only in the descriptor that receives the first byte of the frame. A zero-capacity descriptor is closed with bit 9 clear and the length unchanged, and byteReady is 0 in that cycle.
- R5: Bit 8 is set in the descriptor where the frame ends or is truncated, and clear in every other word.
- R6: If a descriptor closes full before the end of frame while nextOwned is 0, its word has bits 8, 14 and 15 set. The remaining bytes up to the end-of-frame mark are accepted and discarded with no further word, and the next start of frame begins a new frame.
- R7: In a last word, bit 15 is the OR of bits 14, 11, 7, 6, 4, 3 and 1. In a non-last word, every bit other than 29:16, 9 and 8 is 0.
- R8: The MAC flags are taken with the end-of-frame byte and land in the last word: giant/checksum in bit 7, late collision in bit 6, frame type in bit 5, watchdog in bit 4, receive error in bit 3 and CRC error in bit 1. A truncated word carries none of them.
- R9: Bit 12 (length error) is set only when the length flag is set, the frame-type flag is clear and the CRC flag is clear.
- R10: Bit 11 (overflow) reflects the overflow flag only when threshMode is 1. In store-and-forward mode (threshMode 0) the flag has no effect on the word.
- R11: Bytes that arrive while no frame is open and without a start-of-frame mark are ignored and produce no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| byteValid | input | 1 | A received byte is present |
| byteSof | input | 1 | Byte is the first of a frame |
| byteEof | input | 1 | Byte is the last of a frame |
| byteReady | output | 1 | Byte is taken this cycle (low while an empty descriptor is closed) |
| buf1Size | input | BUF_W | Size of buffer 1 of the current descriptor |
| buf2Size | input | BUF_W | Size of buffer 2 of the current descriptor |
| nextOwned | input | 1 | Next descriptor is owned by the DMA |
| threshMode | input | 1 | 1: threshold mode, 0: store-and-forward |
| errGiant | input | 1 | Giant frame or checksum fault |
| errLateColl | input | 1 | Late collision |
| errWatchdog | input | 1 | Receive watchdog timeout |
| errRecv | input | 1 | Receive error from the PHY |
| errCrc | input | 1 | CRC mismatch |
| errLength | input | 1 | Length field mismatch |
| frameTypeIn | input | 1 | Frame carries a type field rather than a length |
| errOverflow | input | 1 | Receive FIFO overflow damaged the frame |
| statusWord | output | 32 | Status word for the closed descriptor |
| statusWe | output | 1 | One-cycle write strobe for statusWord |

## Verification
The hardest state to reach combines an empty descriptor with a chain that runs out of owned descriptors in the middle of a frame, where a byte is held back and a truncation may follow right after. The bench builds a descriptor table that steps forward in the same cycle as each strobe. It sweeps both buffer sizes of the first descriptor over 0 to 2, three shapes for the following descriptors, frame lengths of 1 to 6 bytes, and ownership that ends two descriptors in. This brings about zero-size skips, exact fills at the end of a frame and truncation. A separate long frame across two maximum-size descriptors drives the length into saturation.

// File: rtl/rxds_pkg.sv
package rxds_pkg;

  localparam int LEN_W = 14;

  typedef struct packed {
    logic frameStart;
    logic take;
    logic close;
    logic last;
    logic trunc;
    logic endFrame;
  } rxdsStrb_t;

  typedef struct packed {
    logic giant;
    logic lateColl;
    logic watchdog;
    logic rxErr;
    logic crcErr;
    logic lenErr;
    logic frameType;
    logic overflow;
  } rxdsErr_t;

endpackage

// File: rtl/rxds_ctrl.sv
module rxds_ctrl
  import rxds_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      byteValid,
  input  logic      byteSof,
  input  logic      byteEof,
  input  logic      nextOwned,
  input  logic      capZero,
  input  logic      fillHit,
  output rxdsStrb_t strb,
  output logic      byteReady
);

  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_DROP} rxdsState_e;

  rxdsState_e state, stateNext;
  logic frameOpen, zeroClose;

  always_comb begin
    strb            = '0;
    strb.frameStart = (state == ST_IDLE) && byteValid && byteSof;
    frameOpen       = strb.frameStart || (state == ST_FILL);
    zeroClose       = frameOpen && capZero;
    strb.take       = frameOpen && byteValid && !capZero;
    strb.endFrame   = strb.take && byteEof;
    strb.close      = zeroClose || (strb.take && fillHit) || strb.endFrame;
    strb.trunc      = strb.close && !strb.endFrame && !nextOwned;
    strb.last       = strb.endFrame || strb.trunc;
    byteReady       = !zeroClose;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (strb.frameStart) begin
          if (strb.trunc)         stateNext = ST_DROP;
          else if (!strb.endFrame) stateNext = ST_FILL;
        end
      end
      ST_FILL: begin
        if (strb.trunc)         stateNext = ST_DROP;
        else if (strb.endFrame) stateNext = ST_IDLE;
      end
      ST_DROP: begin
        if (byteValid && byteEof) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // A truncation always leads into the discard state (R6).
  assert_trunc_drop_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.trunc |=> (state == ST_DROP));

  // Bytes are held back only to close an empty descriptor, never while discarding (R4).
  assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !byteReady |-> (capZero && state != ST_DROP));

endmodule

// File: rtl/rxds_dpath.sv
module rxds_dpath
  import rxds_pkg::*;
#(
  parameter int BUF_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxdsStrb_t        strb,
  input  logic [BUF_W-1:0] buf1Size,
  input  logic [BUF_W-1:0] buf2Size,
  input  rxdsErr_t         errIn,
  input  logic             threshMode,
  output logic             capZero,
  output logic             fillHit,
  output logic [31:0]      statusWord,
  output logic             statusWe
);

  localparam int CNT_W = BUF_W + 1;
  localparam logic [LEN_W-1:0] LEN_MAX = '1;

  logic [CNT_W-1:0] descCnt, curCnt, newCnt, cap;
  logic [LEN_W-1:0] runLen, curLen, newLen;
  logic firstDone, firstInDesc, firstDoneEff, firstInDescEff, fsNow;
  logic [31:0] word;

  always_comb begin
    cap            = {1'b0, buf1Size} + {1'b0, buf2Size};
    capZero        = (cap == '0);
    curCnt         = strb.frameStart ? '0 : descCnt;
    curLen         = strb.frameStart ? '0 : runLen;
    firstDoneEff   = strb.frameStart ? 1'b0 : firstDone;
    firstInDescEff = strb.frameStart ? 1'b0 : firstInDesc;
    fillHit        = ((curCnt + CNT_W'(1)) == cap);
    newCnt         = curCnt + CNT_W'(strb.take);
    newLen         = (strb.take && curLen != LEN_MAX) ? curLen + LEN_W'(1) : curLen;
    fsNow          = firstInDescEff | (strb.take & ~firstDoneEff);
  end

  always_comb begin
    word         = '0;
    word[29:16]  = newLen;
    word[9]      = fsNow;
    word[8]      = strb.last;
    word[14]     = strb.trunc;
    if (strb.endFrame) begin
      word[7]  = errIn.giant;
      word[6]  = errIn.lateColl;
      word[5]  = errIn.frameType;
      word[4]  = errIn.watchdog;
      word[3]  = errIn.rxErr;
      word[1]  = errIn.crcErr;
      word[12] = errIn.lenErr & ~errIn.frameType & ~errIn.crcErr;
      word[11] = errIn.overflow & threshMode;
    end
    word[15] = strb.last & (word[14] | word[11] | word[7] | word[6] |
                            word[4] | word[3] | word[1]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descCnt     <= '0;
      runLen      <= '0;
      firstDone   <= 1'b0;
      firstInDesc <= 1'b0;
      statusWe    <= 1'b0;
      statusWord  <= '0;
    end else begin
      descCnt     <= strb.close ? '0 : newCnt;
      runLen      <= newLen;
      firstDone   <= strb.last ? 1'b0 : (firstDoneEff | strb.take);
      firstInDesc <= strb.close ? 1'b0 : fsNow;
      statusWe    <= strb.close;
      if (strb.close) statusWord <= word;
    end
  end

  // Summary bit of a closing word agrees with the error bits (R7).
  assert_es_summary_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusWe && statusWord[8]) |->
      (statusWord[15] == (statusWord[14] | statusWord[11] | statusWord[7] |
                          statusWord[6] | statusWord[4] | statusWord[3] | statusWord[1])));

  // Intermediate words carry only length and placement flags (R7).
  assert_nonlast_clean_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusWe && !statusWord[8]) |-> ((statusWord & 32'h0000_FCFF) == 32'h0));

  // Length error never coexists with a type frame or a CRC fault (R9).
  assert_le_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    (statusWe && statusWord[12]) |-> (!statusWord[5] && !statusWord[1]));

  // Overflow is reported only in threshold mode (R10).
  assert_oe_mode_R10: assert property (@(posedge clk) disable iff (!rstN)
    (statusWe && statusWord[11]) |-> $past(threshMode));

endmodule

// File: rtl/rx_desc_status_writer.sv
module rx_desc_status_writer
  import rxds_pkg::*;
#(
  parameter int BUF_W = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             byteValid,
  input  logic             byteSof,
  input  logic             byteEof,
  output logic             byteReady,
  input  logic [BUF_W-1:0] buf1Size,
  input  logic [BUF_W-1:0] buf2Size,
  input  logic             nextOwned,
  input  logic             threshMode,
  input  logic             errGiant,
  input  logic             errLateColl,
  input  logic             errWatchdog,
  input  logic             errRecv,
  input  logic             errCrc,
  input  logic             errLength,
  input  logic             frameTypeIn,
  input  logic             errOverflow,
  output logic [31:0]      statusWord,
  output logic             statusWe
);

  rxdsStrb_t strb;
  rxdsErr_t  errIn;
  logic      capZero, fillHit;

  always_comb begin
    errIn.giant     = errGiant;
    errIn.lateColl  = errLateColl;
    errIn.watchdog  = errWatchdog;
    errIn.rxErr     = errRecv;
    errIn.crcErr    = errCrc;
    errIn.lenErr    = errLength;
    errIn.frameType = frameTypeIn;
    errIn.overflow  = errOverflow;
  end

  rxds_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .byteSof   (byteSof),
    .byteEof   (byteEof),
    .nextOwned (nextOwned),
    .capZero   (capZero),
    .fillHit   (fillHit),
    .strb      (strb),
    .byteReady (byteReady)
  );

  rxds_dpath #(.BUF_W(BUF_W)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .buf1Size   (buf1Size),
    .buf2Size   (buf2Size),
    .errIn      (errIn),
    .threshMode (threshMode),
    .capZero    (capZero),
    .fillHit    (fillHit),
    .statusWord (statusWord),
    .statusWe   (statusWe)
  );

endmodule

// File: tb/rx_desc_status_writer_tb_top.sv
`timescale 1ns/1ps
module rx_desc_status_writer_tb_top;

  localparam int BW = 13;

  logic clk = 0;
  logic rstN = 0;
  logic byteValid = 0, byteSof = 0, byteEof = 0;
  logic byteReady;
  logic [BW-1:0] buf1Size, buf2Size;
  logic nextOwned;
  logic threshMode = 0;
  logic errGiant = 0, errLateColl = 0, errWatchdog = 0, errRecv = 0;
  logic errCrc = 0, errLength = 0, frameTypeIn = 0, errOverflow = 0;
  logic [31:0] statusWord;
  logic statusWe;

  always #4 clk = ~clk;

  logic [BW-1:0] tbSz1 [0:255];
  logic [BW-1:0] tbSz2 [0:255];
  bit            tbOwn [0:255];
  logic [7:0] pulseCount = 0;
  logic [7:0] descIdx, nxtIdx;

  assign descIdx   = pulseCount + {7'b0, statusWe};
  assign nxtIdx    = descIdx + 8'd1;
  assign buf1Size  = tbSz1[descIdx];
  assign buf2Size  = tbSz2[descIdx];
  assign nextOwned = tbOwn[nxtIdx];

  always @(posedge clk) if (statusWe) pulseCount <= pulseCount + 8'd1;

  rx_desc_status_writer #(.BUF_W(BW)) dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteSof(byteSof),
    .byteEof(byteEof), .byteReady(byteReady), .buf1Size(buf1Size),
    .buf2Size(buf2Size), .nextOwned(nextOwned), .threshMode(threshMode),
    .errGiant(errGiant), .errLateColl(errLateColl), .errWatchdog(errWatchdog),
    .errRecv(errRecv), .errCrc(errCrc), .errLength(errLength),
    .frameTypeIn(frameTypeIn), .errOverflow(errOverflow),
    .statusWord(statusWord), .statusWe(statusWe)
  );

  logic [31:0] capWords [0:63];
  int capN = 0;
  logic [31:0] expWords [0:63];
  string expTag [0:63];
  int expN = 0;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always @(posedge clk) begin
    #2;
    if (statusWe) begin
      if (capN < 64) capWords[capN] = statusWord;
      capN++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // e: 0 giant, 1 late, 2 wdt, 3 rxerr, 4 crc, 5 length, 6 type, 7 overflow
  function automatic logic [31:0] mkWord(int len, bit fs, bit ls, bit de, bit endOk,
                                         logic [7:0] e, bit thr);
    logic [31:0] w = '0;
    w[29:16] = 14'(len);
    w[9] = fs; w[8] = ls; w[14] = de;
    if (endOk) begin
      w[7] = e[0]; w[6] = e[1]; w[4] = e[2]; w[3] = e[3]; w[1] = e[4];
      w[5] = e[6];
      w[12] = e[5] & ~e[6] & ~e[4];
      w[11] = e[7] & thr;
    end
    if (ls) w[15] = w[14] | w[11] | w[7] | w[6] | w[4] | w[3] | w[1];
    return w;
  endfunction

  task automatic sendByte(input bit s, input bit e);
    bit rdy = 0;
    while (!rdy) begin
      @(negedge clk);
      byteValid = 1; byteSof = s; byteEof = e;
      #1;
      rdy = byteReady;
    end
  endtask

  task automatic runFrame(input int n, input int a, input int b, input int c, input int d,
                          input bit tr, input logic [7:0] e, input bit thr);
    logic [7:0] k;
    int placed, cap, take, lenv;
    bit firstPend;
    @(negedge clk);
    k = descIdx;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] j = k + 8'(i);
      tbSz1[j] = BW'(i == 0 ? a : c);
      tbSz2[j] = BW'(i == 0 ? b : d);
      tbOwn[j] = !(tr && i == 2);
    end
    {errOverflow, frameTypeIn, errLength, errCrc, errRecv, errWatchdog, errLateColl, errGiant} = e;
    threshMode = thr;
    // expected words
    expN = 0; placed = 0; firstPend = 1;
    for (int guard = 0; guard < 60; guard++) begin
      cap  = int'(tbSz1[k]) + int'(tbSz2[k]);
      take = (cap < n - placed) ? cap : n - placed;
      placed += take;
      lenv = placed > 16383 ? 16383 : placed;
      if (placed == n && take > 0) begin
        expTag[expN] = "R5/R7/R8/R9/R10";
        expWords[expN++] = mkWord(lenv, firstPend, 1, 0, 1, e, thr);
        break;
      end else if (!tbOwn[k + 8'd1]) begin
        expTag[expN] = "R6";
        expWords[expN++] = mkWord(lenv, firstPend && take > 0, 1, 1, 0, e, thr);
        break;
      end else begin
        expTag[expN] = (take == 0) ? "R4" : "R2";
        expWords[expN++] = mkWord(lenv, firstPend && take > 0, 0, 0, 0, e, thr);
      end
      if (take > 0) firstPend = 0;
      k = k + 8'd1;
    end
    capN = 0;
    for (int i = 0; i < n; i++) sendByte(i == 0, i == n - 1);
    @(negedge clk);
    byteValid = 0; byteSof = 0; byteEof = 0;
    repeat (4) @(negedge clk);
    chk(capN == expN, "R3 word count", 32'(capN), 32'(expN));
    for (int i = 0; i < expN && i < capN; i++)
      chk(capWords[i] == expWords[i], expTag[i], capWords[i], expWords[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    int f = 0;
    for (int i = 0; i < 256; i++) begin tbSz1[i] = 1; tbSz2[i] = 1; tbOwn[i] = 1; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(statusWe == 0, "R1 strobe", 32'(statusWe), 0);
    chk(statusWord == 0, "R1 word", statusWord, 0);
    chk(byteReady == 1, "R1 ready", 32'(byteReady), 1);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R11: stray bytes without a frame start
    capN = 0;
    sendByte(0, 0); sendByte(0, 0); sendByte(0, 1);
    @(negedge clk); byteValid = 0; byteEof = 0;
    repeat (4) @(negedge clk);
    chk(capN == 0, "R11 stray bytes", 32'(capN), 0);

    // sweep
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int cf = 0; cf < 3; cf++)
          for (int n = 1; n <= 6; n++)
            for (int tr = 0; tr < 2; tr++) begin
              int c = (cf == 0) ? 1 : (cf == 1) ? 0 : 2;
              int d = (cf == 0) ? 1 : (cf == 1) ? 3 : 0;
              logic [7:0] e = 8'(f * 29 + 7);
              runFrame(n, a, b, c, d, bit'(tr), e, bit'((f >> 1) & 1));
              f++;
            end

    // R10: overflow ignored in store-and-forward, shown in threshold mode
    runFrame(3, 2, 2, 1, 1, 0, 8'h80, 0);
    runFrame(3, 2, 2, 1, 1, 0, 8'h80, 1);

    // R2: saturation across two maximum-size descriptors, then restart
    runFrame(16400, 8191, 8191, 8191, 8191, 0, 8'h00, 0);
    runFrame(2, 1, 0, 1, 0, 0, 8'h00, 0);

    done = 1;
    finishRun();
  end

endmodule